// File: doc/BRIEF.md
# NAND Die Command Interpreter

This block models the control logic of a NAND flash die for use in verification environments. A host drives a byte-wide bus. Each byte is tagged as a command, an address or a data byte. The block decodes these cycles into page program, block erase, page read, status read and reset operations. Program, erase and read run as busy intervals whose length is set by parameters counted in clock cycles. While an operation is in flight, `rb_n` is low and the ready bit of the status byte reads 0.

The storage is a small array of blocks, pages and bytes, all parameters. Programming can only clear bits: each stored byte is ANDed with the loaded byte. Erase returns a whole block to all ones. The block also enforces two usage rules:
- Pages of a block must be programmed in ascending order.
- A page may only be programmed a limited number of times before its block is erased.

Breaking either rule sets the fail bit, and the array is left unchanged.

Read data and status leave through a valid/ready stream. While `out_valid` is high, `out_byte` holds its value until `out_ready` completes a transfer. Only a transfer in page-data mode advances the column; status mode can be sampled at any time without side effects. The input bus has a ready signal. `bus_ready` drops only while a reset recovers, and a byte offered then is not taken.

Top module: `nce_cmd_engine`

## Requirements
- R1: While a program, erase or read is busy, only the status commands (8'h70 or 8'h78) and reset (8'hFF) are accepted. Every other command, address byte and data byte is ignored and changes neither the array nor the output mode.
- R2: `rb_n` is 0 while an operation is busy and 1 otherwise. Status byte bit 6 is 1 when ready and 0 when busy, so an idle, passing device reads 8'h40. A program keeps the device busy for exactly PROG_CYC cycles after its confirm byte, and an erase for exactly ERASE_CYC cycles.
- R3: Status byte bit 0 is the fail flag. It is set at the end of a failed program, cleared when a program or erase starts, and cleared by reset.
- R4: After a status command, the output stream presents the status byte until another valid command is latched. Address bytes, data bytes and unrecognised or out-of-sequence commands leave status mode in place.
- R5: A program stores old AND new in each byte of the page, so no bit ever goes from 0 to 1. Bytes not loaded after 8'h80 are loaded as 8'hFF and keep their value.
- R6: An erase needs 8'h60, two address bytes and 8'h D0. Any other command after 8'h60 abandons it, and nothing is erased. An erase sets every byte of the addressed block to 8'hFF.
- R7: Erase ignores the page field of the address; the page bits may hold any value.
- R8: Programming a page lower than the highest page programmed in that block since its last erase sets fail and leaves the array unchanged.
- R9: Programming a page that has already been programmed NOP times since its block's last erase sets fail and leaves the array unchanged.
- R10: Reset (8'hFF) aborts any busy operation without changing the array. It holds `bus_ready` and `rb_n` low for RST_CYC cycles and then leaves the block idle and ready, with fail cleared.
- R11: A read is 8'h00, three address bytes and 8'h30. After READ_CYC busy cycles the stream presents bytes from the given column. The column increments on each page-data transfer and wraps at the end of the page. `out_valid` is low while busy.
- R12: On the bus, `bus_kind` 0 is a command, 1 an address byte and 2 a data byte. Program and read take their address bytes in the order column, row low, row high. Erase takes row low, then row high. In row low, bits [PG_W-1:0] select the page and the next BLK_W bits select the block. The row high byte is accepted but unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host offers a bus byte |
| bus_ready | output | 1 | Block can take a bus byte (low during reset recovery) |
| bus_kind | input | 2 | 0 command, 1 address, 2 data |
| bus_byte | input | 8 | Bus byte |
| out_valid | output | 1 | Status or page data available |
| out_ready | input | 1 | Host takes the output byte |
| out_byte | output | 8 | Status byte or page data byte |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
A bus byte is taken on the rising edge where `bus_valid` and `bus_ready` are both high. Mode changes and the start of a busy interval are visible at the next falling edge, so the bench samples a status byte at the falling edge right after its 8'h70 cycle. Busy intervals are checked at two falling edges: `rb_n` (or `bus_ready` for reset) must still be low N-1 edges after the confirm, and high one edge later. For program this is N = PROG_CYC, for erase ERASE_CYC and for reset RST_CYC. Array contents are checked only through later reads, and each sampled byte is compared with a value computed from the AND-only, erase-to-ones rules.

// File: rtl/nce_pkg.sv
package nce_pkg;
  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2
  } bus_kind_e;

  localparam logic [7:0] OPC_READ     = 8'h00;
  localparam logic [7:0] OPC_READ_GO  = 8'h30;
  localparam logic [7:0] OPC_LOAD     = 8'h80;
  localparam logic [7:0] OPC_PROG_GO  = 8'h10;
  localparam logic [7:0] OPC_ERASE    = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO = 8'hD0;
  localparam logic [7:0] OPC_STAT     = 8'h70;
  localparam logic [7:0] OPC_STAT_ALT = 8'h78;
  localparam logic [7:0] OPC_RESET    = 8'hFF;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_P_ADDR, SQ_P_DATA, SQ_E_ADDR, SQ_E_WAIT, SQ_R_ADDR, SQ_R_WAIT
  } seq_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_ERASE, OP_READ, OP_RST
  } op_e;

  typedef enum logic [1:0] {
    OM_NONE, OM_STAT, OM_DATA
  } omode_e;
endpackage

// File: rtl/nce_busy_timer.sv
module nce_busy_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= load;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1)) && !start;

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy); // R2
endmodule

// File: rtl/nce_page_guard.sv
module nce_page_guard #(
  parameter int BLOCKS = 4,
  parameter int PAGES  = 4,
  parameter int NOP    = 2,
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int PG_W  = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] q_blk,
  input  logic [PG_W-1:0]  q_pg,
  output logic             viol,
  input  logic             prog_en,
  input  logic [BLK_W-1:0] prog_blk,
  input  logic [PG_W-1:0]  prog_pg,
  input  logic             erase_en,
  input  logic [BLK_W-1:0] erase_blk
);
  localparam int NOP_W = $clog2(NOP + 1);
  localparam int NPG   = BLOCKS * PAGES;
  localparam logic [NOP_W-1:0] NOP_LIM = NOP_W'(NOP);

  logic             used   [BLOCKS];
  logic [PG_W-1:0]  top_pg [BLOCKS];
  logic [NOP_W-1:0] nop_cnt[NPG];

  always_comb begin
    viol = (used[q_blk] && (q_pg < top_pg[q_blk])) ||
           (nop_cnt[{q_blk, q_pg}] >= NOP_LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        used[b]   <= 1'b0;
        top_pg[b] <= '0;
      end
      for (int i = 0; i < NPG; i++) nop_cnt[i] <= '0;
    end else if (erase_en) begin
      used[erase_blk]   <= 1'b0;
      top_pg[erase_blk] <= '0;
      for (int p = 0; p < PAGES; p++) nop_cnt[{erase_blk, PG_W'(p)}] <= '0;
    end else if (prog_en) begin
      used[prog_blk]   <= 1'b1;
      top_pg[prog_blk] <= prog_pg;
      nop_cnt[{prog_blk, prog_pg}] <= nop_cnt[{prog_blk, prog_pg}] + 1'b1;
    end
  end

  AST_NOP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> nop_cnt[{prog_blk, prog_pg}] < NOP_LIM); // R9
  AST_PAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en && used[prog_blk] |-> prog_pg >= top_pg[prog_blk]); // R8
endmodule

// File: rtl/nce_cell_array.sv
module nce_cell_array #(
  parameter int BLOCKS     = 4,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 8,
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int PG_W  = $clog2(PAGES),
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_en,
  input  logic [BLK_W-1:0]        prog_blk,
  input  logic [PG_W-1:0]         prog_pg,
  input  logic [PAGE_BYTES*8-1:0] prog_page,
  input  logic                    erase_en,
  input  logic [BLK_W-1:0]        erase_blk,
  input  logic [BLK_W-1:0]        rd_blk,
  input  logic [PG_W-1:0]         rd_pg,
  input  logic [COL_W-1:0]        rd_col,
  output logic [7:0]              rd_byte
);
  localparam int WORDS = BLOCKS * PAGES * PAGE_BYTES;

  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
    end else if (erase_en) begin
      for (int p = 0; p < PAGES; p++)
        for (int c = 0; c < PAGE_BYTES; c++)
          mem[{erase_blk, PG_W'(p), COL_W'(c)}] <= 8'hFF;
    end else if (prog_en) begin
      for (int c = 0; c < PAGE_BYTES; c++)
        mem[{prog_blk, prog_pg, COL_W'(c)}] <=
          mem[{prog_blk, prog_pg, COL_W'(c)}] & prog_page[c*8 +: 8];
    end
  end

  assign rd_byte = mem[{rd_blk, rd_pg, rd_col}];

  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en)); // R6
endmodule

// File: rtl/nce_cmd_engine.sv
module nce_cmd_engine
  import nce_pkg::*;
#(
  parameter int BLOCKS     = 4,
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 8,
  parameter int NOP        = 2,
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 30,
  parameter int READ_CYC   = 5,
  parameter int RST_CYC    = 4,
  parameter int CNT_W      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  output logic       bus_ready,
  input  logic [1:0] bus_kind,
  input  logic [7:0] bus_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       rb_n
);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int PG_W  = $clog2(PAGES);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = BLK_W + PG_W;

  seq_e   seq;
  op_e    op;
  omode_e omode;
  logic [1:0]              acnt;
  logic [COL_W-1:0]        col;
  logic [ROW_W-1:0]        row;
  logic [PAGE_BYTES*8-1:0] page_buf;
  logic                    fail, pend_viol;
  logic [BLK_W-1:0]        tgt_blk, rd_blk;
  logic [PG_W-1:0]         tgt_pg, rd_pg;

  logic busy, tmr_done, tmr_start, viol;
  logic [CNT_W-1:0] tmr_load;
  logic [7:0] arr_byte;

  logic accept, is_cmd, is_addr, is_data, out_fire;
  logic arr_prog, arr_erase;
  logic [BLK_W-1:0] row_blk;
  logic [PG_W-1:0]  row_pg;

  assign bus_ready = !(busy && op == OP_RST);
  assign accept    = bus_valid && bus_ready;
  assign is_cmd    = accept && bus_kind == BK_CMD;
  assign is_addr   = accept && bus_kind == BK_ADDR;
  assign is_data   = accept && bus_kind == BK_DATA;
  assign row_pg    = row[PG_W-1:0];
  assign row_blk   = row[ROW_W-1:PG_W];

  always_comb begin
    tmr_start = 1'b0;
    tmr_load  = '0;
    if (is_cmd) begin
      if (bus_byte == OPC_RESET) begin
        tmr_start = 1'b1;
        tmr_load  = CNT_W'(RST_CYC);
      end else if (!busy) begin
        if (bus_byte == OPC_PROG_GO && seq == SQ_P_DATA) begin
          tmr_start = 1'b1;
          tmr_load  = CNT_W'(PROG_CYC);
        end else if (bus_byte == OPC_ERASE_GO && seq == SQ_E_WAIT) begin
          tmr_start = 1'b1;
          tmr_load  = CNT_W'(ERASE_CYC);
        end else if (bus_byte == OPC_READ_GO && seq == SQ_R_WAIT) begin
          tmr_start = 1'b1;
          tmr_load  = CNT_W'(READ_CYC);
        end
      end
    end
  end

  nce_busy_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load),
    .busy(busy), .done(tmr_done)
  );

  assign arr_prog  = tmr_done && op == OP_PROG && !pend_viol;
  assign arr_erase = tmr_done && op == OP_ERASE;

  nce_page_guard #(.BLOCKS(BLOCKS), .PAGES(PAGES), .NOP(NOP)) guard_i (
    .clk(clk), .rst_n(rst_n), .q_blk(row_blk), .q_pg(row_pg), .viol(viol),
    .prog_en(arr_prog), .prog_blk(tgt_blk), .prog_pg(tgt_pg),
    .erase_en(arr_erase), .erase_blk(tgt_blk)
  );

  nce_cell_array #(.BLOCKS(BLOCKS), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) array_i (
    .clk(clk), .rst_n(rst_n),
    .prog_en(arr_prog), .prog_blk(tgt_blk), .prog_pg(tgt_pg), .prog_page(page_buf),
    .erase_en(arr_erase), .erase_blk(tgt_blk),
    .rd_blk(rd_blk), .rd_pg(rd_pg), .rd_col(col), .rd_byte(arr_byte)
  );

  assign out_valid = (omode == OM_STAT) || (omode == OM_DATA && !busy);
  assign out_byte  = (omode == OM_STAT) ? {1'b0, !busy, 5'b0, fail} : arr_byte;
  assign out_fire  = out_valid && out_ready && omode == OM_DATA;
  assign rb_n      = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= SQ_IDLE; op <= OP_NONE; omode <= OM_NONE;
      acnt <= '0; col <= '0; row <= '0; page_buf <= '1;
      fail <= 1'b0; pend_viol <= 1'b0;
      tgt_blk <= '0; tgt_pg <= '0; rd_blk <= '0; rd_pg <= '0;
    end else begin
      if (tmr_done) begin
        if (op == OP_PROG) fail <= pend_viol;
        op <= OP_NONE;
      end
      if (is_cmd) begin
        if (bus_byte == OPC_RESET) begin
          seq <= SQ_IDLE; op <= OP_RST; omode <= OM_NONE; fail <= 1'b0;
        end else if (bus_byte == OPC_STAT || bus_byte == OPC_STAT_ALT) begin
          omode <= OM_STAT;
          if (!busy) seq <= SQ_IDLE;
        end else if (!busy) begin
          case (bus_byte)
            OPC_LOAD: begin
              seq <= SQ_P_ADDR; acnt <= '0; omode <= OM_NONE; page_buf <= '1;
            end
            OPC_ERASE: begin
              seq <= SQ_E_ADDR; acnt <= '0; omode <= OM_NONE;
            end
            OPC_READ: begin
              seq <= SQ_R_ADDR; acnt <= '0; omode <= OM_NONE;
            end
            OPC_PROG_GO: if (seq == SQ_P_DATA) begin
              seq <= SQ_IDLE; op <= OP_PROG; omode <= OM_NONE; fail <= 1'b0;
              pend_viol <= viol; tgt_blk <= row_blk; tgt_pg <= row_pg;
            end
            OPC_ERASE_GO: if (seq == SQ_E_WAIT) begin
              seq <= SQ_IDLE; op <= OP_ERASE; omode <= OM_NONE; fail <= 1'b0;
              tgt_blk <= row_blk;
            end
            OPC_READ_GO: if (seq == SQ_R_WAIT) begin
              seq <= SQ_IDLE; op <= OP_READ; omode <= OM_DATA;
              rd_blk <= row_blk; rd_pg <= row_pg;
            end
            default: ;
          endcase
        end
      end else if (is_addr && !busy) begin
        case (seq)
          SQ_P_ADDR, SQ_R_ADDR: begin
            acnt <= acnt + 1'b1;
            if (acnt == 2'd0) col <= bus_byte[COL_W-1:0];
            else if (acnt == 2'd1) row <= bus_byte[ROW_W-1:0];
            else seq <= (seq == SQ_P_ADDR) ? SQ_P_DATA : SQ_R_WAIT;
          end
          SQ_E_ADDR: begin
            acnt <= acnt + 1'b1;
            if (acnt == 2'd0) row <= bus_byte[ROW_W-1:0];
            else seq <= SQ_E_WAIT;
          end
          default: ;
        endcase
      end else if (is_data && !busy && seq == SQ_P_DATA) begin
        page_buf[int'(col)*8 +: 8] <= bus_byte;
        col <= col + 1'b1;
      end
      if (out_fire) col <= col + 1'b1;
    end
  end

  AST_BUSY_SEQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> seq == SQ_IDLE); // R1
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_done && !is_cmd |=> $stable(fail)); // R3
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    omode == OM_STAT && !is_cmd |=> omode == OM_STAT); // R4
  AST_NO_DATA_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && omode != OM_STAT |-> !out_valid); // R11
endmodule

// File: tb/nce_cmd_engine_tb.sv
module nce_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC = 20, ERASE_CYC = 30, READ_CYC = 5, RST_CYC = 4;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_ready, out_valid, out_ready = 0, rb_n;
  logic [1:0] bus_kind = 0;
  logic [7:0] bus_byte = 0, out_byte;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nce_cmd_engine #(.BLOCKS(4), .PAGES(4), .PAGE_BYTES(8), .NOP(2),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .READ_CYC(READ_CYC),
    .RST_CYC(RST_CYC), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_kind(bus_kind), .bus_byte(bus_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .rb_n(rb_n));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [1:0] k, logic [7:0] b);
    bus_valid = 1; bus_kind = k; bus_byte = b;
    @(negedge clk);
    bus_valid = 0;
  endtask
  task automatic cmd(logic [7:0] b);  drive(2'd0, b); endtask
  task automatic adr(logic [7:0] b);  drive(2'd1, b); endtask
  task automatic dat(logic [7:0] b);  drive(2'd2, b); endtask

  task automatic wait_rdy();
    for (int i = 0; i < 1000 && !(rb_n && bus_ready); i++) @(negedge clk);
  endtask

  function automatic logic [7:0] rowof(int blk, int pg);
    return 8'((blk << 2) | pg);
  endfunction

  task automatic prog(int blk, int pg, int n, logic [7:0] b0, logic [7:0] b1, bit timed);
    cmd(8'h80); adr(8'h00); adr(rowof(blk, pg)); adr(8'h00);
    dat(b0);
    if (n > 1) dat(b1);
    cmd(8'h10);
    if (timed) begin
      repeat (PROG_CYC - 1) @(negedge clk);
      chk("R2 rb_n low at last program busy cycle", {7'b0, rb_n}, 8'h00);
      @(negedge clk);
      chk("R2 rb_n high after PROG_CYC", {7'b0, rb_n}, 8'h01);
    end
    wait_rdy();
  endtask

  task automatic stat(string tag, logic [7:0] exp);
    cmd(8'h70);
    chk(tag, out_byte, exp);
  endtask

  task automatic rd(string tag, int blk, int pg, int c, logic [7:0] exp);
    cmd(8'h00); adr(8'(c)); adr(rowof(blk, pg)); adr(8'h00); cmd(8'h30);
    chk("R11 out_valid low while read busy", {7'b0, out_valid}, 8'h00);
    wait_rdy();
    chk(tag, out_byte, exp);
  endtask

  task automatic rd_next(string tag, logic [7:0] exp);
    out_ready = 1; @(negedge clk); out_ready = 0;
    chk(tag, out_byte, exp);
  endtask

  task automatic t_reset_state();
    chk("R2 rb_n after reset", {7'b0, rb_n}, 8'h01);
    chk("R10 bus_ready after reset", {7'b0, bus_ready}, 8'h01);
    chk("R11 out_valid idle", {7'b0, out_valid}, 8'h00);
    stat("R2 status idle", 8'h40);
  endtask

  task automatic t_program_basic();
    prog(0, 0, 2, 8'hA5, 8'h3C, 1);
    stat("R3 status after good program", 8'h40);
    rd("R11 read col0", 0, 0, 0, 8'hA5);
    rd_next("R11 stream col1", 8'h3C);
    rd_next("R5 unloaded byte", 8'hFF);
  endtask

  task automatic t_program_and();
    prog(0, 0, 2, 8'hFF, 8'h0F, 0);
    stat("R9 second partial allowed", 8'h40);
    rd("R5 FF keeps 0 bits", 0, 0, 0, 8'hA5);
    rd_next("R5 AND result", 8'h0C);
  endtask

  task automatic t_nop();
    prog(0, 0, 1, 8'h00, 8'h00, 0);
    stat("R9 NOP exceeded sets fail", 8'h41);
    rd("R9 array unchanged", 0, 0, 0, 8'hA5);
  endtask

  task automatic t_order();
    prog(0, 2, 1, 8'h77, 8'h00, 0);
    stat("R8 ascending page ok", 8'h40);
    prog(0, 1, 1, 8'h00, 8'h00, 0);
    stat("R8 lower page fails", 8'h41);
    rd("R8 lower page untouched", 0, 1, 0, 8'hFF);
    rd("R8 higher page kept", 0, 2, 0, 8'h77);
  endtask

  task automatic t_busy_ignore();
    cmd(8'h80); adr(8'h00); adr(rowof(1, 0)); adr(8'h00); dat(8'h11); cmd(8'h10);
    cmd(8'h70);
    chk("R2 status busy", out_byte, 8'h00);
    cmd(8'h00); adr(8'h00); dat(8'h00);
    cmd(8'h60); adr(rowof(0, 0)); adr(8'h00); cmd(8'hD0);
    wait_rdy();
    chk("R1 status mode kept through busy", {7'b0, out_valid}, 8'h01);
    chk("R4 status after busy", out_byte, 8'h40);
    rd("R1 program not disturbed", 1, 0, 0, 8'h11);
    rd("R1 erase ignored while busy", 0, 0, 0, 8'hA5);
  endtask

  task automatic t_sticky();
    cmd(8'h70);
    adr(8'h12); dat(8'h34); cmd(8'hD0);
    chk("R4 sticky valid", {7'b0, out_valid}, 8'h01);
    chk("R4 sticky status", out_byte, 8'h40);
  endtask

  task automatic t_erase_abort();
    cmd(8'h60); adr(rowof(0, 0)); adr(8'h00); cmd(8'h70); cmd(8'hD0);
    chk("R6 no busy without confirm", {7'b0, rb_n}, 8'h01);
    rd("R6 abandoned erase", 0, 0, 0, 8'hA5);
  endtask

  task automatic t_erase();
    cmd(8'h60); adr(rowof(0, 3)); adr(8'h00); cmd(8'hD0);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk("R2 busy at last erase cycle", {7'b0, rb_n}, 8'h00);
    @(negedge clk);
    chk("R2 ready after ERASE_CYC", {7'b0, rb_n}, 8'h01);
    stat("R3 erase status", 8'h40);
    rd("R7 page0 erased", 0, 0, 0, 8'hFF);
    rd("R6 page2 erased", 0, 2, 0, 8'hFF);
    rd("R6 other block kept", 1, 0, 0, 8'h11);
    prog(0, 1, 1, 8'h5A, 8'h00, 0);
    stat("R8 order restarts after erase", 8'h40);
    rd("R6 program after erase", 0, 1, 0, 8'h5A);
  endtask

  task automatic t_reset_abort();
    prog(1, 3, 1, 8'h22, 8'h00, 0);
    prog(1, 1, 1, 8'h00, 8'h00, 0);
    stat("R3 fail before reset", 8'h41);
    cmd(8'hFF);
    wait_rdy();
    stat("R10 reset clears fail", 8'h40);
    cmd(8'h80); adr(8'h00); adr(rowof(2, 0)); adr(8'h00); dat(8'h00); cmd(8'h10);
    repeat (3) @(negedge clk);
    cmd(8'hFF);
    repeat (RST_CYC - 1) @(negedge clk);
    chk("R10 bus_ready low in recovery", {7'b0, bus_ready}, 8'h00);
    @(negedge clk);
    chk("R10 bus_ready after RST_CYC", {7'b0, bus_ready}, 8'h01);
    chk("R10 rb_n after reset", {7'b0, rb_n}, 8'h01);
    rd("R10 aborted program left array", 2, 0, 0, 8'hFF);
  endtask

  task automatic t_wrap();
    rd("R11 read last column", 0, 1, 7, 8'hFF);
    rd_next("R11 column wraps", 8'h5A);
    cmd(8'h00);
    chk("R12 read cmd ends data mode", {7'b0, out_valid}, 8'h00);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_program_basic();
    t_program_and();
    t_nop();
    t_order();
    t_busy_ignore();
    t_sticky();
    t_erase_abort();
    t_erase();
    t_reset_abort();
    t_wrap();
    finish_run();
  end
endmodule